// File: doc/BRIEF.md
# Digital Phase-Frequency Detector with Pump Polarity and Float Control

This block compares two divided clocks, a feedback clock derived from the oscillator and a reference clock, and produces the three control lines of a tri-state charge pump. A "source" request tells the pump to push current into the loop filter. A "sink" request tells it to pull current out. The enable line tells the pump to drive at all. When the enable line is low, the pump floats and the loop filter holds its voltage. Both comparison clocks are sampled by a fast system clock. The comparison rate must stay well below that sampling rate, and in the target loop it is at most 2 MHz.

The detector keeps one flag per clock input. A rising edge on that input sets the flag. Once both flags are up, a small timer runs for a fixed number of cycles and then clears both flags together. This minimum overlap keeps the transfer characteristic linear with no dead zone. A polarity input swaps which flag drives source and which drives sink. A disable input forces the pump to float whatever the phase error.

Top module: `pfd_core`

## Requirements
- R1: While `rst` is high at a clock edge, both flags and the edge history are cleared on that edge. From that edge on, `src_o`, `snk_o` and `oe_o` are all 0.
- R2: With `pol_i`=0, a rising edge of `fr_i` seen at a clock edge sets the reference flag, and `src_o` is 1 from that edge. A rising edge of `fv_i` sets the feedback flag in the same way, and `snk_o` is 1 from that edge.
- R3: With `pol_i`=1, the mapping is swapped: the reference flag drives `snk_o` and the feedback flag drives `src_o`.
- R4: Once both flags are set, they stay set together for exactly `RST_DLY` clock cycles. Both are then cleared on the same edge.
- R5: `oe_o` is 1 only when exactly one of `src_o` and `snk_o` is 1.
- R6: While `dis_i` is 1, `src_o`, `snk_o` and `oe_o` are all 0. The flags keep following the inputs, so when `dis_i` goes back to 0 the outputs show the current flag state at once.
- R7: When `fv_i` and `fr_i` rise on the same sampled edge, `oe_o` stays 0 for the whole cycle of the two inputs.
- R8: A flag is set only by a 0-to-1 change of its input between two samples. An input held high does not set the flag again after it has been cleared.
- R9: A rising edge that arrives on the same clock edge as the clear wins, so that flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| fv_i | input | 1 | Divided feedback clock |
| fr_i | input | 1 | Divided reference clock |
| pol_i | input | 1 | 1 swaps the source and sink mapping |
| dis_i | input | 1 | 1 forces the pump to float |
| src_o | output | 1 | Source current request |
| snk_o | output | 1 | Sink current request |
| oe_o | output | 1 | Pump drive enable |

## Verification
A flag stuck high, or one that misses an edge, makes the pump drive in one direction without end. The bench sees this on the cycle after the missed or stuck edge, as a lasting disagreement on `src_o`/`snk_o`. A wrong overlap count shortens or lengthens the coincident pulse by whole cycles, and this shows at the first pair of edges. The bench compares all three outputs against a behavioural model on every cycle, so any such fault is reported within one cycle of its first visible effect.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  typedef struct packed {
    logic src;
    logic snk;
    logic oe;
  } pump_t;

  // Polarity mapping and float gating, kept as a function so the
  // mapping can be restated independently elsewhere.
  function automatic pump_t pump_map(input logic ref_f, input logic vco_f,
                                     input logic pol, input logic dis);
    pump_t p;
    p.src = dis ? 1'b0 : (pol ? vco_f : ref_f);
    p.snk = dis ? 1'b0 : (pol ? ref_f : vco_f);
    p.oe  = p.src ^ p.snk;
    return p;
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sig_i;
  end

  assign rise_o = sig_i & ~prev_q & ~rst;

endmodule

// File: rtl/pfd_flag.sv
module pfd_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  p_set_r2: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> flag_o);
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i && flag_o) |=> flag_o);

endmodule

// File: rtl/pfd_clr_timer.sv
module pfd_clr_timer #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic both_i,
  output logic clr_o
);
  localparam int CW = (RST_DLY < 2) ? 1 : $clog2(RST_DLY);
  localparam logic [CW-1:0] LAST = CW'(RST_DLY - 1);

  logic [CW-1:0] cnt_q;

  assign clr_o = both_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !both_i || clr_o) cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  p_clr_needs_both_r4: assert property (@(posedge clk) disable iff (rst)
    clr_o |-> both_i);
  p_no_early_clr_r4: assert property (@(posedge clk) disable iff (rst)
    (both_i && !clr_o) |=> (!both_i || cnt_q != '0));

endmodule

// File: rtl/pfd_core.sv
module pfd_core
  import pfd_pkg::*;
#(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic fv_i,
  input  logic fr_i,
  input  logic pol_i,
  input  logic dis_i,
  output logic src_o,
  output logic snk_o,
  output logic oe_o
);
  localparam int NCH = 2;   // channel 0: reference, channel 1: feedback

  logic [NCH-1:0] in_v;
  logic [NCH-1:0] rise_v;
  logic [NCH-1:0] flag_v;
  logic           both_w;
  logic           clr_w;
  pump_t          pump_w;

  assign in_v = {fv_i, fr_i};

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      pfd_edge u_edge (
        .clk(clk), .rst(rst), .sig_i(in_v[g]), .rise_o(rise_v[g])
      );
      pfd_flag u_flag (
        .clk(clk), .rst(rst), .set_i(rise_v[g]), .clr_i(clr_w),
        .flag_o(flag_v[g])
      );
    end
  endgenerate

  assign both_w = &flag_v;

  pfd_clr_timer #(.RST_DLY(RST_DLY)) u_timer (
    .clk(clk), .rst(rst), .both_i(both_w), .clr_o(clr_w)
  );

  assign pump_w = pump_map(flag_v[0], flag_v[1], pol_i, dis_i);
  assign src_o  = pump_w.src;
  assign snk_o  = pump_w.snk;
  assign oe_o   = pump_w.oe;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (flag_v == '0));
  p_oe_one_r5: assert property (@(posedge clk) disable iff (rst)
    oe_o |-> $onehot({src_o, snk_o}));
  p_dis_float_r6: assert property (@(posedge clk) disable iff (rst)
    dis_i |-> (!oe_o && !src_o && !snk_o));
  p_pol_swap_r3: assert property (@(posedge clk) disable iff (rst)
    (pol_i && !dis_i && flag_v[0] && !flag_v[1]) |-> (snk_o && !src_o));
  p_clr_both_r4: assert property (@(posedge clk) disable iff (rst)
    (clr_w && rise_v == '0) |=> (flag_v == '0));

endmodule

// File: tb/pfd_core_tb_top.sv
module pfd_core_tb_top;
  localparam int D = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fv = 1'b0, fr = 1'b0, pol = 1'b0, dis = 1'b0;
  logic src, snk, oe;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  // behavioural model state
  int m_pv = 0, m_pr = 0, m_fvf = 0, m_frf = 0, m_cnt = 0;
  int oe_seen = 0;

  always #2 clk = ~clk;

  pfd_core #(.RST_DLY(D)) dut_i (
    .clk(clk), .rst(rst), .fv_i(fv), .fr_i(fr), .pol_i(pol), .dis_i(dis),
    .src_o(src), .snk_o(snk), .oe_o(oe)
  );

  always @(posedge clk) begin
    int ev, er, both, clr;
    if (rst) begin
      m_pv = 0; m_pr = 0; m_fvf = 0; m_frf = 0; m_cnt = 0;
    end else begin
      ev = (fv && !m_pv) ? 1 : 0;
      er = (fr && !m_pr) ? 1 : 0;
      both = m_fvf && m_frf;
      clr = both && (m_cnt == D - 1);
      m_cnt = (both && !clr) ? m_cnt + 1 : 0;
      m_fvf = ev ? 1 : (clr ? 0 : m_fvf);
      m_frf = er ? 1 : (clr ? 0 : m_frf);
      m_pv = fv; m_pr = fr;
    end
  end

  task automatic compare();
    int es, ek, eo;
    if (dis) begin es = 0; ek = 0; end
    else if (!pol) begin es = m_frf; ek = m_fvf; end
    else begin es = m_fvf; ek = m_frf; end
    eo = (es != ek) ? 1 : 0;
    checks++;
    if (src !== 1'(es) || snk !== 1'(ek) || oe !== 1'(eo)) begin
      errors++;
      $display("FAIL %s: src/snk/oe = %b%b%b expected %0d%0d%0d at %0t",
               tag, src, snk, oe, es, ek, eo, $time);
    end
    if (oe === 1'b1) oe_seen++;
  endtask

  task automatic step(input logic nfr, input logic nfv);
    @(negedge clk);
    compare();
    fr = nfr; fv = nfv;
  endtask

  // square waves with periods pr/pv, feedback offset off cycles
  task automatic run(input int n, input int pr, input int pv, input int off);
    for (int t = 0; t < n; t++)
      step(((t % pr) < pr / 2), (((t + off) % pv) < pv / 2));
  endtask

  task automatic single(input string name, input int cond);
    checks++;
    if (cond == 0) begin
      errors++;
      $display("FAIL %s: condition 0 expected 1 at %0t", name, $time);
    end
  endtask

  initial begin : wd
    #400000;
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    repeat (3) step(1'b0, 1'b0);
    rst = 1'b0;
    // R2: reference leads feedback -> source pulses; feedback leads -> sink
    tag = "R2";
    run(200, 20, 20, 5);
    run(200, 20, 20, 15);
    run(300, 20, 17, 0);
    // R3: polarity swapped
    tag = "R3";
    pol = 1'b1;
    run(200, 20, 20, 5);
    run(300, 20, 23, 0);
    pol = 1'b0;
    // R4 / R7: coincident edges, minimum pulse only, no drive
    tag = "R7";
    oe_seen = 0;
    run(200, 16, 16, 0);
    single("R7 oe stayed low", oe_seen == 0 ? 1 : 0);
    // R4 explicit overlap length: both rise together, check both high D cycles
    tag = "R4";
    step(1'b0, 1'b0);
    step(1'b1, 1'b1);
    for (int k = 0; k < D; k++) begin
      @(negedge clk);
      single("R4 overlap held", (m_frf == 1 && m_fvf == 1 && src && snk) ? 1 : 0);
    end
    @(negedge clk);
    single("R4 cleared together", (!src && !snk && !oe) ? 1 : 0);
    // R8: held-high inputs do not retrigger
    tag = "R8";
    repeat (10) step(1'b1, 1'b1);
    single("R8 no retrigger", (!src && !snk) ? 1 : 0);
    // R9: edge on clear cycle
    tag = "R9";
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    repeat (6) step(1'b1, 1'b1);
    run(100, 3, 5, 1);
    // R6: disable forces float, flags keep tracking
    tag = "R6";
    dis = 1'b1;
    run(150, 20, 20, 6);
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    step(1'b1, 1'b0);
    dis = 1'b0;
    @(negedge clk);
    single("R6 flag visible after enable", (src && !snk && oe) ? 1 : 0);
    // R5: mixed patterns, oe exclusivity via model compare
    tag = "R5";
    run(400, 11, 13, 3);
    pol = 1'b1;
    run(200, 9, 7, 2);
    // R1: reset mid-run
    tag = "R1";
    step(1'b1, 1'b0);
    rst = 1'b1;
    step(1'b0, 1'b1);
    @(negedge clk);
    single("R1 outputs floated", (!src && !snk && !oe) ? 1 : 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule